// File: doc/BRIEF.md
# SDRAM Command Legality Monitor

This block is a passive observer placed beside a synchronous DRAM command bus. Every rising clock edge it samples chip select, the three strobe lines, clock enable, the bank select and the auto-precharge/all-banks address bit. It keeps its own model of each bank: idle, row open, read burst, write burst or precharging. It also models a refresh that covers the whole device. Any command that the current bank states forbid is reported with its own error code, and a sticky flag records that at least one violation has been seen.

The monitor never drives the memory. An illegal command is reported and then ignored, so the model keeps the state that a well-behaved device would hold. Three cycle windows are parameters: row open to column access, precharge to the next activate, and refresh duration. A fixed burst length is also a parameter. Each window restricts the N cycles that follow the command that opened it. The first cycle in which the window no longer applies is cycle N+1 after that command.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: A cycle with cs_n high, or a NOP (cs_n low, {ras_n,cas_n,we_n}=111), never raises an error and does not disturb any burst, precharge or refresh countdown.
- R2: With cs_n low, {ras_n,cas_n,we_n} decodes as 011 activate, 101 read, 100 write, 110 burst stop, 010 precharge, 001 refresh, 000 mode load, 111 NOP. A legal command gives err_code 0.
- R3: A read or write is flagged with code 2 when the addressed bank has no open row. It is flagged with code 5 when it comes within the T_RCD cycles after that bank's activate.
- R4: A refresh or mode load while any bank is not idle is flagged with code 3.
- R5: A burst stop addressed to a bank that is not in a read or write burst is flagged with code 4. A burst stop to the bank in a burst ends that burst and leaves its row open.
- R6: During the T_RFC cycles after an accepted refresh, any command other than NOP is flagged with code 1. Code 1 is also given to any command aimed at a bank that is precharging because of auto precharge.
- R7: An activate to a bank inside its T_RP precharge window after a plain precharge is flagged with code 6. An activate to a bank whose row is already open is flagged with code 7.
- R8: A read, write, burst stop or precharge addressed to a bank whose current burst has auto precharge set is flagged with code 8. A read or write to the other bank is legal: it cuts that burst short, and the cut bank then starts its T_RP auto precharge.
- R9: When cke is sampled low while any bank is in a burst, the command is ignored with no error, and all bank state and countdowns hold for that cycle. With no burst running, a low cke does not suspend checking.
- R10: err_code is registered and shows the result of the command sampled at the previous edge. Codes are checked in the order 1, 3, 1, 8, then the per-command codes. An illegal command changes no state. err_sticky rises with the first nonzero code and clears only on reset, which also returns every bank to idle.
- R11: a10 high on a precharge closes every bank. a10 high on a read or write sets auto precharge for that burst. A burst lasts BURST_LEN cycles after its command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge samples the command |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| cke | input | 1 | Clock enable as seen by the memory |
| ba | input | BAW | Bank select |
| a10 | input | 1 | All-banks / auto-precharge select bit |
| err_code | output | 4 | Violation code of the previous command, 0 when legal |
| err_sticky | output | 1 | Set by any violation, cleared by reset |

## Verification
A wrong bank state inside the monitor stays hidden until some command probes it. The fault then shows as a wrong err_code exactly one cycle after that command, either a false violation or a missed one. A countdown that is off by one cycle changes the result only at the edge of a window. For that reason the stimulus places commands on the last restricted cycle and on the first free cycle of every window. Suspension and cut-short bursts shift later window edges, so their effect is checked by commands issued several cycles afterwards.

// File: rtl/sdram_mon_pkg.sv
package sdram_mon_pkg;

  typedef enum logic [2:0] {
    BK_IDLE = 3'd0,
    BK_OPEN = 3'd1,
    BK_RD   = 3'd2,
    BK_WR   = 3'd3,
    BK_PRE  = 3'd4
  } bank_st_t;

  typedef enum logic [2:0] {
    OP_LMR = 3'b000,
    OP_REF = 3'b001,
    OP_PRE = 3'b010,
    OP_ACT = 3'b011,
    OP_WR  = 3'b100,
    OP_RD  = 3'b101,
    OP_BST = 3'b110,
    OP_NOP = 3'b111
  } opcode_t;

  typedef enum logic [2:0] {
    BA_NONE  = 3'd0,
    BA_OPEN  = 3'd1,
    BA_RD    = 3'd2,
    BA_WR    = 3'd3,
    BA_STOP  = 3'd4,
    BA_CLOSE = 3'd5
  } bank_act_t;

  localparam int ERR_W = 4;
  localparam logic [ERR_W-1:0] ERR_NONE     = 4'd0;
  localparam logic [ERR_W-1:0] ERR_BUSY     = 4'd1;
  localparam logic [ERR_W-1:0] ERR_NOT_OPEN = 4'd2;
  localparam logic [ERR_W-1:0] ERR_NOT_IDLE = 4'd3;
  localparam logic [ERR_W-1:0] ERR_NO_BURST = 4'd4;
  localparam logic [ERR_W-1:0] ERR_RCD      = 4'd5;
  localparam logic [ERR_W-1:0] ERR_RP       = 4'd6;
  localparam logic [ERR_W-1:0] ERR_ROW_OPEN = 4'd7;
  localparam logic [ERR_W-1:0] ERR_AP_LOCK  = 4'd8;

  function automatic bit in_burst(bank_st_t s);
    return (s == BK_RD) || (s == BK_WR);
  endfunction

  function automatic bit row_open(bank_st_t s);
    return (s == BK_OPEN) || (s == BK_RD) || (s == BK_WR);
  endfunction

  function automatic int ctr_bits(int n);
    return (n < 1) ? 1 : $clog2(n + 1);
  endfunction

  function automatic int max3(int a, int b, int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/sdram_mon_decode.sv
module sdram_mon_decode
  import sdram_mon_pkg::*;
(
  input  logic    cs_n,
  input  logic    ras_n,
  input  logic    cas_n,
  input  logic    we_n,
  output opcode_t op,
  output logic    live
);

  // chip select high reads as NOP so inhibit never reaches the rules
  assign op   = cs_n ? OP_NOP : opcode_t'({ras_n, cas_n, we_n});
  assign live = (op != OP_NOP);

endmodule

// File: rtl/sdram_mon_bank.sv
module sdram_mon_bank
  import sdram_mon_pkg::*;
#(
  parameter int T_RCD     = 3,
  parameter int T_RP      = 3,
  parameter int BURST_LEN = 4
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      freeze,
  input  bank_act_t act,
  input  logic      ap_set,
  output bank_st_t  st,
  output logic      ap,
  output logic      tmr_zero
);

  localparam int TW = ctr_bits(max3(T_RCD, T_RP, BURST_LEN));

  bank_st_t        st_q, st_d;
  logic [TW-1:0]   tmr_q, tmr_d;
  logic            ap_q, ap_d;

  always_comb begin
    st_d  = st_q;
    tmr_d = tmr_q;
    ap_d  = ap_q;
    // natural evolution of the countdowns
    if (in_burst(st_q) && tmr_q == '0) begin
      if (ap_q) begin
        st_d  = BK_PRE;
        tmr_d = TW'(T_RP - 1);
      end else begin
        st_d = BK_OPEN;
      end
    end else if (st_q == BK_PRE && tmr_q == '0) begin
      st_d = BK_IDLE;
      ap_d = 1'b0;
    end else if (tmr_q != '0) begin
      tmr_d = tmr_q - 1'b1;
    end
    // accepted commands override
    case (act)
      BA_OPEN: begin
        st_d  = BK_OPEN;
        tmr_d = TW'(T_RCD);
        ap_d  = 1'b0;
      end
      BA_RD, BA_WR: begin
        st_d  = (act == BA_RD) ? BK_RD : BK_WR;
        tmr_d = TW'(BURST_LEN - 1);
        ap_d  = ap_set;
      end
      BA_STOP: begin
        if (ap_q) begin
          st_d  = BK_PRE;
          tmr_d = TW'(T_RP - 1);
        end else begin
          st_d  = BK_OPEN;
          tmr_d = '0;
        end
      end
      BA_CLOSE: begin
        if (row_open(st_q)) begin
          st_d  = BK_PRE;
          tmr_d = TW'(T_RP - 1);
          ap_d  = 1'b0;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= BK_IDLE;
      tmr_q <= '0;
      ap_q  <= 1'b0;
    end else if (!freeze) begin
      st_q  <= st_d;
      tmr_q <= tmr_d;
      ap_q  <= ap_d;
    end
  end

  assign st       = st_q;
  assign ap       = ap_q;
  assign tmr_zero = (tmr_q == '0);

  // R9: a suspended cycle holds the bank model
  assert_suspend_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |=> ($stable(st_q) && $stable(tmr_q)));

  // R8: cutting an auto-precharge burst enters its precharge
  assert_ap_cut_precharges_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!freeze && ap_q && in_burst(st_q) && act == BA_STOP) |=> (st_q == BK_PRE && ap_q));

  // R3: a column access is only ever applied to an open row
  assert_access_needs_row_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!freeze && (act == BA_RD || act == BA_WR)) |-> row_open(st_q));

endmodule

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor
  import sdram_mon_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int T_RCD     = 3,
  parameter int T_RP      = 3,
  parameter int T_RFC     = 7,
  parameter int BURST_LEN = 4,
  localparam int BAW      = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             ras_n,
  input  logic             cas_n,
  input  logic             we_n,
  input  logic             cke,
  input  logic [BAW-1:0]   ba,
  input  logic             a10,
  output logic [ERR_W-1:0] err_code,
  output logic             err_sticky
);

  localparam int RW = ctr_bits(T_RFC);

  opcode_t              op;
  logic                 live;
  bank_st_t             bk_st [NUM_BANKS];
  logic                 bk_ap [NUM_BANKS];
  logic                 bk_tz [NUM_BANKS];
  logic [NUM_BANKS-1:0] tgt;
  logic                 all_idle, burst_any, ap_pre_hit, ap_burst_hit;
  logic                 freeze, accept;
  logic [ERR_W-1:0]     code;
  logic                 ref_busy;
  logic [RW-1:0]        ref_tmr;
  bank_st_t             sel_st;
  logic                 sel_tz;

  sdram_mon_decode u_dec (
    .cs_n (cs_n),
    .ras_n(ras_n),
    .cas_n(cas_n),
    .we_n (we_n),
    .op   (op),
    .live (live)
  );

  // banks touched by the current command
  always_comb begin
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (op == OP_REF || op == OP_LMR || (op == OP_PRE && a10))
        tgt[b] = 1'b1;
      else
        tgt[b] = (ba == BAW'(b));
    end
  end

  always_comb begin
    all_idle     = 1'b1;
    burst_any    = 1'b0;
    ap_pre_hit   = 1'b0;
    ap_burst_hit = 1'b0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bk_st[b] != BK_IDLE) all_idle = 1'b0;
      if (in_burst(bk_st[b])) burst_any = 1'b1;
      if (tgt[b] && bk_ap[b] && bk_st[b] == BK_PRE) ap_pre_hit = 1'b1;
      if (tgt[b] && bk_ap[b] && in_burst(bk_st[b])) ap_burst_hit = 1'b1;
    end
  end

  assign sel_st = bk_st[ba];
  assign sel_tz = bk_tz[ba];
  assign freeze = !cke && burst_any;

  // rule table, first match wins
  always_comb begin
    code = ERR_NONE;
    if (freeze || !live) begin
      code = ERR_NONE;
    end else if (ref_busy) begin
      code = ERR_BUSY;
    end else if (op == OP_REF || op == OP_LMR) begin
      code = all_idle ? ERR_NONE : ERR_NOT_IDLE;
    end else if (ap_pre_hit) begin
      code = ERR_BUSY;
    end else if (ap_burst_hit) begin
      code = ERR_AP_LOCK;
    end else begin
      case (op)
        OP_ACT: begin
          if (sel_st == BK_PRE)       code = ERR_RP;
          else if (sel_st != BK_IDLE) code = ERR_ROW_OPEN;
        end
        OP_RD, OP_WR: begin
          if (!row_open(sel_st))                 code = ERR_NOT_OPEN;
          else if (sel_st == BK_OPEN && !sel_tz) code = ERR_RCD;
        end
        OP_BST: begin
          if (!in_burst(sel_st)) code = ERR_NO_BURST;
        end
        default: ;
      endcase
    end
  end

  assign accept = live && !freeze && (code == ERR_NONE);

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    bank_act_t act_g;
    logic      own_g;
    assign own_g = (ba == BAW'(g));

    always_comb begin
      act_g = BA_NONE;
      if (accept) begin
        case (op)
          OP_ACT: if (own_g) act_g = BA_OPEN;
          OP_RD:  act_g = own_g ? BA_RD : (in_burst(bk_st[g]) ? BA_STOP : BA_NONE);
          OP_WR:  act_g = own_g ? BA_WR : (in_burst(bk_st[g]) ? BA_STOP : BA_NONE);
          OP_BST: if (own_g) act_g = BA_STOP;
          OP_PRE: if (tgt[g]) act_g = BA_CLOSE;
          default: ;
        endcase
      end
    end

    sdram_mon_bank #(
      .T_RCD    (T_RCD),
      .T_RP     (T_RP),
      .BURST_LEN(BURST_LEN)
    ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .freeze  (freeze),
      .act     (act_g),
      .ap_set  (a10),
      .st      (bk_st[g]),
      .ap      (bk_ap[g]),
      .tmr_zero(bk_tz[g])
    );
  end

  // device-wide refresh window
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_busy <= 1'b0;
      ref_tmr  <= '0;
    end else if (!freeze) begin
      if (accept && op == OP_REF) begin
        ref_busy <= 1'b1;
        ref_tmr  <= RW'(T_RFC - 1);
      end else if (ref_busy) begin
        if (ref_tmr == '0) ref_busy <= 1'b0;
        else               ref_tmr  <= ref_tmr - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_code   <= ERR_NONE;
      err_sticky <= 1'b0;
    end else begin
      err_code   <= code;
      err_sticky <= err_sticky | (code != ERR_NONE);
    end
  end

  // R1: a deselected cycle reports nothing
  assert_inhibit_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (err_code == ERR_NONE));

  // R10: the sticky flag never falls outside reset
  assert_sticky_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err_sticky |=> err_sticky);

  // R10: any reported code is reflected in the sticky flag
  assert_code_sets_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (err_code != ERR_NONE) |-> err_sticky);

  // R4: banks stay idle for the whole refresh window
  assert_refresh_banks_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ref_busy |-> all_idle);

endmodule

// File: tb/tb_sdram_cmd_monitor.sv
`timescale 1ns/1ps
module tb_sdram_cmd_monitor;

  localparam int P_RCD = 3;
  localparam int P_RP  = 3;
  localparam int P_RFC = 7;
  localparam int P_BL  = 4;

  // {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] C_NOP = 4'b0111;
  localparam logic [3:0] C_INH = 4'b1111;
  localparam logic [3:0] C_ACT = 4'b0011;
  localparam logic [3:0] C_RD  = 4'b0101;
  localparam logic [3:0] C_WR  = 4'b0100;
  localparam logic [3:0] C_BST = 4'b0110;
  localparam logic [3:0] C_PRE = 4'b0010;
  localparam logic [3:0] C_REF = 4'b0001;
  localparam logic [3:0] C_LMR = 4'b0000;

  localparam logic [3:0] E_OK  = 4'd0;
  localparam logic [3:0] E_BSY = 4'd1;
  localparam logic [3:0] E_CLS = 4'd2;
  localparam logic [3:0] E_NID = 4'd3;
  localparam logic [3:0] E_BST = 4'd4;
  localparam logic [3:0] E_RCD = 4'd5;
  localparam logic [3:0] E_RP  = 4'd6;
  localparam logic [3:0] E_OPN = 4'd7;
  localparam logic [3:0] E_APL = 4'd8;

  localparam logic H = 1'b1;
  localparam logic L = 1'b0;

  // entry: {cmd[3:0], cke, ba, a10, expected code[3:0]}
  localparam int NV = 62;
  localparam logic [10:0] VEC [NV] = '{
    {C_NOP, H, L, L, E_OK },  // 0  R2 nop
    {C_INH, H, L, L, E_OK },  // 1  R1 inhibit
    {C_RD,  H, L, L, E_CLS},  // 2  R3 closed bank
    {C_BST, H, L, L, E_BST},  // 3  R5 no burst
    {C_ACT, H, L, L, E_OK },  // 4
    {C_RD,  H, L, L, E_RCD},  // 5  R3 window cycle 1
    {C_NOP, H, L, L, E_OK },  // 6
    {C_WR,  H, L, L, E_RCD},  // 7  R3 last restricted cycle
    {C_RD,  H, L, L, E_OK },  // 8  R3 first free cycle
    {C_ACT, H, L, L, E_OPN},  // 9  R7 row open
    {C_REF, H, L, L, E_NID},  // 10 R4
    {C_LMR, H, L, L, E_NID},  // 11 R4
    {C_BST, H, L, L, E_OK },  // 12 R5/R10 burst still alive
    {C_PRE, H, L, L, E_OK },  // 13
    {C_ACT, H, L, L, E_RP },  // 14 R7
    {C_RD,  H, L, L, E_CLS},  // 15 R3 precharging
    {C_PRE, H, L, L, E_OK },  // 16 R7 precharge on precharging bank
    {C_ACT, H, L, L, E_OK },  // 17 R7 window over
    {C_ACT, H, H, L, E_OK },  // 18
    {C_REF, H, L, L, E_NID},  // 19 R4
    {C_NOP, H, L, L, E_OK },  // 20
    {C_WR,  H, L, H, E_OK },  // 21 R11 auto precharge write
    {C_PRE, H, L, L, E_APL},  // 22 R8
    {C_RD,  H, H, L, E_OK },  // 23 R8 cross-bank cut
    {C_ACT, H, L, L, E_BSY},  // 24 R6 auto precharge running
    {C_NOP, H, L, L, E_OK },  // 25
    {C_RD,  H, H, L, E_OK },  // 26
    {C_PRE, H, L, H, E_OK },  // 27 R11 close all
    {C_REF, H, L, L, E_NID},  // 28 R4
    {C_NOP, H, L, L, E_OK },  // 29
    {C_NOP, H, L, L, E_OK },  // 30
    {C_REF, H, L, L, E_OK },  // 31 R11 bank 1 closed by a10
    {C_ACT, H, H, L, E_BSY},  // 32 R6
    {C_NOP, H, L, L, E_OK },  // 33 R1
    {C_INH, H, L, L, E_OK },  // 34 R1
    {C_LMR, H, L, L, E_BSY},  // 35 R6 priority
    {C_NOP, H, L, L, E_OK },  // 36
    {C_NOP, H, L, L, E_OK },  // 37
    {C_ACT, H, L, L, E_BSY},  // 38 R6 last refresh cycle
    {C_ACT, H, L, L, E_OK },  // 39 R6 first free cycle
    {C_LMR, H, L, L, E_NID},  // 40 R4
    {C_NOP, H, L, L, E_OK },  // 41
    {C_NOP, H, L, L, E_OK },  // 42
    {C_RD,  H, L, L, E_OK },  // 43
    {C_RD,  L, H, L, E_OK },  // 44 R9 suspended
    {C_ACT, L, L, L, E_OK },  // 45 R9 suspended
    {C_NOP, H, L, L, E_OK },  // 46
    {C_NOP, H, L, L, E_OK },  // 47
    {C_NOP, H, L, L, E_OK },  // 48
    {C_BST, H, L, L, E_OK },  // 49 R9 burst extended by suspension
    {C_BST, H, L, L, E_BST},  // 50 R5
    {C_WR,  H, H, L, E_CLS},  // 51 R3
    {C_RD,  H, L, H, E_OK },  // 52 R11
    {C_RD,  H, L, L, E_APL},  // 53 R8
    {C_BST, H, L, L, E_APL},  // 54 R8
    {C_NOP, H, L, L, E_OK },  // 55
    {C_NOP, H, L, L, E_OK },  // 56
    {C_RD,  H, L, L, E_BSY},  // 57 R6
    {C_PRE, H, L, H, E_BSY},  // 58 R6 all-bank precharge hits it
    {C_NOP, H, L, L, E_OK },  // 59
    {C_ACT, H, L, L, E_OK },  // 60
    {C_RD,  L, H, L, E_CLS}   // 61 R9 low cke without burst
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic       cke = 1'b1;
  logic [0:0] ba = 1'b0;
  logic       a10 = 1'b0;
  logic [3:0] err_code;
  logic       err_sticky;

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  sdram_cmd_monitor #(
    .NUM_BANKS(2),
    .T_RCD    (P_RCD),
    .T_RP     (P_RP),
    .T_RFC    (P_RFC),
    .BURST_LEN(P_BL)
  ) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .we_n      (we_n),
    .cke       (cke),
    .ba        (ba),
    .a10       (a10),
    .err_code  (err_code),
    .err_sticky(err_sticky)
  );

  function automatic string tag_of(logic [3:0] c);
    case (c)
      E_BSY:        return "R6";
      E_CLS, E_RCD: return "R3";
      E_NID:        return "R4";
      E_BST:        return "R5";
      E_RP, E_OPN:  return "R7";
      E_APL:        return "R8";
      default:      return "R2";
    endcase
  endfunction

  task automatic check(input int act, input int exp, input string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] c, input logic k, input logic b, input logic a);
    {cs_n, ras_n, cas_n, we_n} = c;
    cke = k;
    ba  = b;
    a10 = a;
  endtask

  task automatic step(input logic [3:0] c, input logic b, input logic [3:0] exp, input string what);
    @(negedge clk);
    drive(c, 1'b1, b, 1'b0);
    @(posedge clk);
    #2;
    check(int'(err_code), int'(exp), what);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL R10 watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(int'(err_code), 0, "R10 reset code");
    check(int'(err_sticky), 0, "R10 reset sticky");
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i][10:7], VEC[i][6], VEC[i][5], VEC[i][4]);
      @(posedge clk);
      #2;
      check(int'(err_code), int'(VEC[i][3:0]),
            $sformatf("%s vector %0d", tag_of(VEC[i][3:0]), i));
    end

    @(negedge clk);
    drive(C_NOP, 1'b1, 1'b0, 1'b0);
    check(int'(err_sticky), 1, "R10 sticky after violations");
    @(posedge clk);
    #2;
    check(int'(err_sticky), 1, "R10 sticky holds through legal cycle");

    // R10: reset clears the flag and returns banks to idle
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check(int'(err_sticky), 0, "R10 sticky cleared by reset");
    check(int'(err_code), 0, "R10 code cleared by reset");
    rst_n = 1'b1;
    step(C_REF, 1'b0, E_OK,  "R10 refresh legal after reset");
    step(C_ACT, 1'b1, E_BSY, "R6 activate during refresh");
    check(int'(err_sticky), 1, "R10 sticky set again");

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule